// File: doc/BRIEF.md
# Flash Row Write Controller

This block sequences erase and program operations on an on-chip flash array for a small processor that talks to it through a byte-wide register port. Software sets a 16-bit byte pointer, streams data bytes into an 8-byte holding buffer, and each byte load advances the pointer by one. A control register chooses the target memory, selects erase or program, and enables writing. Before any operation starts, software must write a two-byte unlock key into a dedicated register.

Once a start is accepted, the controller holds a stall output high for a fixed, parameterised number of cycles. While stall is high, the processor is frozen, and the controller drives byte writes on a simple flash port. An erase sets a whole 64-byte row to FFh. A program copies the holding buffer into one aligned 8-byte group, so rewriting a full row takes one erase and eight program operations. When an operation ends, the controller raises a sticky done flag, refills the holding buffer with FFh and clears the unlock state. If a start request is not allowed, nothing happens except that a sticky error flag is set.

Register offsets on `reg_addr`: 0 pointer low byte, 1 pointer high byte, 2 buffer load port, 3 control, 4 unlock key. Control bits: [0] start, [1] write enable, [2] row erase, [3] configuration select, [4] program-memory select, [5] error, [6] done.

Top module: `flw_ctrl_top`

## Requirements
- R1: A write to offset 2 stores the byte into buffer slot pointer[2:0] and then increments the 16-bit pointer. A read of offset 2 returns the buffer byte in slot pointer[2:0] and does not move the pointer.
- R2: The unlock register at offset 4 reaches the armed state only after 55h is written and then AAh is written, with no other register access between them. Any other write, or any read, returns the sequencer to idle.
- R3: A control write with bit 0 set starts an operation only if the sequencer is armed and the same written value has bit 4 set, bit 3 clear and bit 1 set.
- R4: A start request that is not accepted produces no stall and no flash write, and it sets error bit 5. This bit stays set until a control write with bit 5 clear.
- R5: An accepted start with bit 2 set writes FFh to all 64 bytes of the aligned row that contains the pointer, and to no other address.
- R6: An accepted start with bit 2 clear writes the 8 buffer bytes to the aligned 8-byte group. The first buffer load since the last clear fixes this group. If the pointer lies outside that group at the start, the request is rejected as in R4.
- R7: Stall is high for exactly OP_CYCLES cycles after an accepted start. During the operation, control bit 0 reads 1. At the end it reads 0 and done bit 6 is set.
- R8: When an operation completes, every buffer slot reads FFh and the unlock sequencer is idle, so the next start needs a new key.
- R9: After reset the pointer is 0, the control register is 0, every buffer slot is FFh and stall is low.
- R10: Register writes made while stall is high have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data (combinational) |
| stall | output | 1 | Processor stall, high while an operation runs |
| op_done | output | 1 | Sticky done flag (control bit 6) |
| flash_we | output | 1 | Flash byte write strobe |
| flash_addr | output | 16 | Flash byte address |
| flash_wdata | output | 8 | Flash byte data |

## Verification
The assertions assume that the register port never asserts read and write together. They also assume that, after a start is accepted, the requester issues no further accesses until stall falls. The one exception is the deliberate write made during stall to exercise R10. The only effect that write can have is on the pointer, and the R10 check reads the pointer back. The directed tasks issue each access as a single-cycle strobe driven at the falling edge, so every access sits cleanly between key bytes or between operations.

// File: rtl/flw_pkg.sv
package flw_pkg;

    localparam logic [2:0] OFS_PTR_LO = 3'd0;
    localparam logic [2:0] OFS_PTR_HI = 3'd1;
    localparam logic [2:0] OFS_LOAD   = 3'd2;
    localparam logic [2:0] OFS_CTRL   = 3'd3;
    localparam logic [2:0] OFS_KEY    = 3'd4;

    localparam logic [7:0] KEY_BYTE_A = 8'h55;
    localparam logic [7:0] KEY_BYTE_B = 8'hAA;
    localparam logic [7:0] ERASED     = 8'hFF;

    typedef enum logic [1:0] {
        KS_IDLE  = 2'd0,
        KS_HALF  = 2'd1,
        KS_ARMED = 2'd2
    } key_st_e;

    typedef struct packed {
        logic done;
        logic err;
        logic prog_mem;
        logic cfg_sel;
        logic erase;
        logic wen;
        logic start;
    } ctrl_t;

    function automatic ctrl_t ctrl_of(input logic [7:0] b);
        return ctrl_t'(b[6:0]);
    endfunction

    function automatic logic start_allowed(input ctrl_t c);
        return c.wen && c.prog_mem && !c.cfg_sel;
    endfunction

endpackage

// File: rtl/flw_unlock.sv
module flw_unlock
    import flw_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       access,
    input  logic       key_wr,
    input  logic [7:0] wdata,
    input  logic       clear,
    output logic       armed,
    output key_st_e    state
);
    key_st_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d = KS_IDLE;
        end else if (access) begin
            if (key_wr && st_q == KS_IDLE && wdata == KEY_BYTE_A)
                st_d = KS_HALF;
            else if (key_wr && st_q == KS_HALF && wdata == KEY_BYTE_B)
                st_d = KS_ARMED;
            else
                st_d = KS_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= KS_IDLE;
        else     st_q <= st_d;
    end

    assign armed = (st_q == KS_ARMED);
    assign state = st_q;
endmodule

// File: rtl/flw_holdbuf.sv
module flw_holdbuf
    import flw_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int HOLD_B = 8,
    localparam int HB_W  = $clog2(HOLD_B),
    localparam int GRP_W = ADDR_W - HB_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  logic [ADDR_W-1:0]   ptr,
    input  logic [7:0]          wdata,
    input  logic                clear,
    output logic [HOLD_B*8-1:0] bytes_flat,
    output logic [7:0]          slot_byte,
    output logic [GRP_W-1:0]    grp,
    output logic                grp_vld
);
    logic [7:0] mem_q [HOLD_B];

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            for (int i = 0; i < HOLD_B; i++) mem_q[i] <= ERASED;
            grp_vld <= 1'b0;
            grp     <= '0;
        end else if (load) begin
            mem_q[ptr[HB_W-1:0]] <= wdata;
            if (!grp_vld) begin
                grp     <= ptr[ADDR_W-1:HB_W];
                grp_vld <= 1'b1;
            end
        end
    end

    for (genvar g = 0; g < HOLD_B; g++) begin : g_flat
        assign bytes_flat[g*8 +: 8] = mem_q[g];
    end

    assign slot_byte = mem_q[ptr[HB_W-1:0]];
endmodule

// File: rtl/flw_opseq.sv
module flw_opseq
    import flw_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int HOLD_B    = 8,
    parameter int ROW_B     = 64,
    parameter int OP_CYCLES = 100,
    localparam int CNT_W    = $clog2(OP_CYCLES + 1),
    localparam int HB_W     = $clog2(HOLD_B)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                go,
    input  logic                go_erase,
    input  logic [ADDR_W-1:0]   go_base,
    input  logic [HOLD_B*8-1:0] bytes_flat,
    output logic                busy,
    output logic                finish,
    output logic                erase_mode,
    output logic                fl_we,
    output logic [ADDR_W-1:0]   fl_addr,
    output logic [7:0]          fl_wdata
);
    logic [CNT_W-1:0]  cnt_q;
    logic [ADDR_W-1:0] base_q;
    logic [CNT_W-1:0]  n_bytes;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy       <= 1'b0;
            cnt_q      <= '0;
            base_q     <= '0;
            erase_mode <= 1'b0;
        end else if (go && !busy) begin
            busy       <= 1'b1;
            cnt_q      <= '0;
            base_q     <= go_base;
            erase_mode <= go_erase;
        end else if (busy) begin
            if (finish) busy <= 1'b0;
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign finish   = busy && (cnt_q == CNT_W'(OP_CYCLES - 1));
    assign n_bytes  = erase_mode ? CNT_W'(ROW_B) : CNT_W'(HOLD_B);
    assign fl_we    = busy && (cnt_q < n_bytes);
    assign fl_addr  = base_q + ADDR_W'(cnt_q);
    assign fl_wdata = erase_mode ? ERASED : bytes_flat[cnt_q[HB_W-1:0]*8 +: 8];
endmodule

// File: rtl/flw_ctrl_top.sv
module flw_ctrl_top
    import flw_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int HOLD_B    = 8,
    parameter int ROW_B     = 64,
    parameter int OP_CYCLES = 100,
    localparam int HB_W     = $clog2(HOLD_B),
    localparam int ROW_W    = $clog2(ROW_B)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [2:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              stall,
    output logic              op_done,
    output logic              flash_we,
    output logic [ADDR_W-1:0] flash_addr,
    output logic [7:0]        flash_wdata
);
    logic [ADDR_W-1:0]      ptr_q;
    ctrl_t                  ctl_q;
    ctrl_t                  wr_ctl;
    logic                   busy, finish, erase_mode, armed;
    key_st_e                key_state;
    logic [HOLD_B*8-1:0]    buf_flat;
    logic [7:0]             slot_byte;
    logic [ADDR_W-HB_W-1:0] grp;
    logic                   grp_vld;
    logic                   wr_ok, acc, load, start_req, range_ok, go, reject;
    logic [ADDR_W-1:0]      go_base;

    assign wr_ok     = reg_wr && !busy;
    assign acc       = (reg_wr || reg_rd) && !busy;
    assign load      = wr_ok && reg_addr == OFS_LOAD;
    assign wr_ctl    = ctrl_of(reg_wdata);
    assign start_req = wr_ok && reg_addr == OFS_CTRL && wr_ctl.start;
    assign range_ok  = !grp_vld || ptr_q[ADDR_W-1:HB_W] == grp;
    assign go        = start_req && armed && start_allowed(wr_ctl)
                       && (wr_ctl.erase || range_ok);
    assign reject    = start_req && !go;
    assign go_base   = wr_ctl.erase ? {ptr_q[ADDR_W-1:ROW_W], ROW_W'(0)}
                                    : {ptr_q[ADDR_W-1:HB_W], HB_W'(0)};

    flw_unlock u_key (
        .clk(clk), .rst(rst), .access(acc),
        .key_wr(wr_ok && reg_addr == OFS_KEY), .wdata(reg_wdata),
        .clear(finish), .armed(armed), .state(key_state)
    );

    flw_holdbuf #(.ADDR_W(ADDR_W), .HOLD_B(HOLD_B)) u_buf (
        .clk(clk), .rst(rst), .load(load), .ptr(ptr_q), .wdata(reg_wdata),
        .clear(finish), .bytes_flat(buf_flat), .slot_byte(slot_byte),
        .grp(grp), .grp_vld(grp_vld)
    );

    flw_opseq #(.ADDR_W(ADDR_W), .HOLD_B(HOLD_B), .ROW_B(ROW_B),
                .OP_CYCLES(OP_CYCLES)) u_seq (
        .clk(clk), .rst(rst), .go(go), .go_erase(wr_ctl.erase),
        .go_base(go_base), .bytes_flat(buf_flat), .busy(busy),
        .finish(finish), .erase_mode(erase_mode), .fl_we(flash_we),
        .fl_addr(flash_addr), .fl_wdata(flash_wdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
            ctl_q <= '0;
        end else begin
            if (wr_ok && reg_addr == OFS_PTR_LO) ptr_q[7:0] <= reg_wdata;
            if (wr_ok && reg_addr == OFS_PTR_HI) ptr_q[ADDR_W-1:8] <= reg_wdata[ADDR_W-9:0];
            if (load) ptr_q <= ptr_q + 1'b1;
            if (wr_ok && reg_addr == OFS_CTRL) begin
                ctl_q.wen      <= wr_ctl.wen;
                ctl_q.erase    <= wr_ctl.erase;
                ctl_q.cfg_sel  <= wr_ctl.cfg_sel;
                ctl_q.prog_mem <= wr_ctl.prog_mem;
                ctl_q.err      <= (wr_ctl.err && ctl_q.err) || reject;
                ctl_q.done     <= wr_ctl.done && ctl_q.done && !go;
            end
            if (finish) ctl_q.done <= 1'b1;
        end
    end

    always_comb begin
        ctrl_t rd_ctl;
        rd_ctl       = ctl_q;
        rd_ctl.start = busy;
        unique case (reg_addr)
            OFS_PTR_LO: reg_rdata = ptr_q[7:0];
            OFS_PTR_HI: reg_rdata = ptr_q[ADDR_W-1:8];
            OFS_LOAD:   reg_rdata = slot_byte;
            OFS_CTRL:   reg_rdata = {1'b0, rd_ctl};
            default:    reg_rdata = 8'h00;
        endcase
    end

    assign stall   = busy;
    assign op_done = ctl_q.done;
endmodule

// File: rtl/flw_checks.sv
module flw_checks
    import flw_pkg::*;
#(
    parameter int OP_CYCLES = 100
) (
    input logic       clk,
    input logic       rst,
    input logic       stall,
    input logic       flash_we,
    input logic       armed,
    input key_st_e    key_state,
    input logic       reg_wr,
    input logic [2:0] reg_addr,
    input logic [7:0] reg_wdata,
    input logic [7:0] reg_rdata_ctrl_err
);
    int run_cnt;

    always_ff @(posedge clk) begin
        if (rst)        run_cnt <= 0;
        else if (stall) run_cnt <= run_cnt + 1;
        else            run_cnt <= 0;
    end

    // R7: stall window length
    a_r7_stall_len: assert property (@(posedge clk) disable iff (rst)
        $fell(stall) |-> run_cnt == OP_CYCLES);

    // R7/R4: flash is only written inside a stall window
    a_r7_we_in_stall: assert property (@(posedge clk) disable iff (rst)
        flash_we |-> stall);

    // R3: an operation begins only from the armed key state
    a_r3_start_needs_key: assert property (@(posedge clk) disable iff (rst)
        $rose(stall) |-> $past(armed));

    // R4: an unarmed start is refused and flagged
    a_r4_reject_flags: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == OFS_CTRL && reg_wdata[0] && !armed && !stall)
        |=> (!stall && reg_rdata_ctrl_err[0]));

    // R8: key sequencer idle once an operation ends
    a_r8_key_idle_after: assert property (@(posedge clk) disable iff (rst)
        $fell(stall) |-> key_state == KS_IDLE);
endmodule

bind flw_ctrl_top flw_checks #(.OP_CYCLES(OP_CYCLES)) u_checks (
    .clk(clk), .rst(rst), .stall(stall), .flash_we(flash_we),
    .armed(armed), .key_state(key_state), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata_ctrl_err({7'd0, ctl_q.err})
);

// File: tb/tb_flw_ctrl_top.sv
module tb_flw_ctrl_top;
    localparam int OPC = 100;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [7:0]  reg_wdata = 8'd0;
    logic [7:0]  reg_rdata;
    logic        stall, op_done, flash_we;
    logic [15:0] flash_addr;
    logic [7:0]  flash_wdata;

    int n_chk = 0;
    int n_bad = 0;
    bit reported = 0;
    logic [7:0] fmem [256];
    int stray_writes = 0;

    always #2 clk = ~clk;

    flw_ctrl_top #(.OP_CYCLES(OPC)) dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .stall(stall), .op_done(op_done), .flash_we(flash_we),
        .flash_addr(flash_addr), .flash_wdata(flash_wdata)
    );

    initial for (int i = 0; i < 256; i++) fmem[i] = 8'h00;

    always @(posedge clk) begin
        if (flash_we) begin
            if (flash_addr[15:8] != 8'h01) stray_writes++;
            else fmem[flash_addr[7:0]] <= flash_wdata;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic unlock();
        wr(3'd4, 8'h55);
        wr(3'd4, 8'hAA);
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (stall && n < 10000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic set_ptr(input logic [15:0] p);
        wr(3'd0, p[7:0]);
        wr(3'd1, p[15:8]);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        chk(stall == 1'b0, "R9 stall", stall, 0);
        rd(3'd0, v); chk(v == 8'h00, "R9 ptr lo", v, 0);
        rd(3'd3, v); chk(v == 8'h00, "R9 ctrl", v, 0);
        rd(3'd2, v); chk(v == 8'hFF, "R9 buffer", v, 8'hFF);
    endtask

    task automatic t_load_ptr();
        logic [7:0] v;
        set_ptr(16'h0106);
        wr(3'd2, 8'h5A);
        wr(3'd2, 8'hC3);
        rd(3'd0, v); chk(v == 8'h08, "R1 ptr incr", v, 8'h08);
        rd(3'd1, v); chk(v == 8'h01, "R1 ptr hi", v, 8'h01);
        wr(3'd0, 8'h06);
        rd(3'd2, v); chk(v == 8'h5A, "R1 slot6", v, 8'h5A);
        rd(3'd2, v); chk(v == 8'h5A, "R1 read no incr", v, 8'h5A);
        wr(3'd0, 8'h07);
        rd(3'd2, v); chk(v == 8'hC3, "R1 slot7", v, 8'hC3);
    endtask

    task automatic t_key_rules();
        logic [7:0] v;
        wr(3'd3, 8'h00);
        wr(3'd4, 8'h55); rd(3'd0, v); wr(3'd4, 8'hAA);
        wr(3'd3, 8'h13);
        chk(stall == 1'b0, "R2 read breaks key", stall, 0);
        rd(3'd3, v); chk(v[5] == 1'b1, "R2 err after broken key", v, 8'h20);
        wr(3'd3, 8'h00);
        rd(3'd3, v); chk(v[5] == 1'b0, "R4 err clears", v, 0);
        wr(3'd4, 8'h55); wr(3'd4, 8'h55); wr(3'd4, 8'hAA);
        wr(3'd3, 8'h13);
        chk(stall == 1'b0, "R2 repeated first byte", stall, 0);
        wr(3'd3, 8'h20);
        rd(3'd3, v); chk(v[5] == 1'b1, "R4 err sticky", v, 8'h20);
        wr(3'd3, 8'h00);
        unlock(); wr(3'd3, 8'h11);
        chk(stall == 1'b0, "R3 no write enable", stall, 0);
        unlock(); wr(3'd3, 8'h1B);
        chk(stall == 1'b0, "R3 config select", stall, 0);
        unlock(); wr(3'd3, 8'h03);
        chk(stall == 1'b0, "R3 no program mem", stall, 0);
        rd(3'd3, v); chk(v[5] == 1'b1, "R4 err set", v, 8'h20);
        chk(stray_writes == 0 && fmem[8'h06] == 8'h00, "R4 no flash write", stray_writes, 0);
        wr(3'd3, 8'h00);
    endtask

    task automatic t_range_and_program();
        logic [7:0] v;
        int n;
        set_ptr(16'h0108);
        unlock(); wr(3'd3, 8'h13);
        chk(stall == 1'b0, "R6 out of group rejected", stall, 0);
        rd(3'd3, v); chk(v[5] == 1'b1, "R6 range err", v, 8'h20);
        set_ptr(16'h0103);
        unlock(); wr(3'd3, 8'h13);
        chk(stall == 1'b1, "R6 in group accepted", stall, 1);
        rd(3'd3, v); chk(v[0] == 1'b1, "R7 start reads 1", v, 1);
        wr(3'd0, 8'h99);
        wait_idle(n);
        rd(3'd0, v); chk(v == 8'h03, "R10 write ignored in stall", v, 8'h03);
        chk(fmem[8'h06] == 8'h5A && fmem[8'h07] == 8'hC3 && fmem[8'h00] == 8'hFF,
            "R6 group data", fmem[8'h06], 8'h5A);
        chk(fmem[8'h08] == 8'h00, "R6 no write past group", fmem[8'h08], 0);
        rd(3'd3, v); chk(v[6] == 1'b1 && v[0] == 1'b0, "R7 done and start clear", v, 8'h40);
        for (int s = 0; s < 8; s++) begin
            wr(3'd0, 8'(s));
            rd(3'd2, v); chk(v == 8'hFF, "R8 buffer cleared", v, 8'hFF);
        end
        wr(3'd3, 8'h13);
        chk(stall == 1'b0, "R8 key needed again", stall, 0);
        wr(3'd3, 8'h00);
    endtask

    task automatic t_row_update();
        logic [7:0] v;
        int n;
        set_ptr(16'h0155);
        unlock(); wr(3'd3, 8'h17);
        wait_idle(n);
        chk(n == OPC, "R7 stall length", n, OPC);
        for (int i = 0; i < 64; i++)
            chk(fmem[8'h40 + i] == 8'hFF, "R5 row erased", fmem[8'h40 + i], 8'hFF);
        chk(fmem[8'h3F] == 8'h00 && fmem[8'h80] == 8'h00, "R5 neighbours kept",
            fmem[8'h3F], 0);
        rd(3'd3, v); chk(v[6] == 1'b1, "R7 done after erase", v, 8'h40);
        for (int g = 0; g < 8; g++) begin
            set_ptr(16'h0140 + 16'(g * 8));
            for (int b = 0; b < 8; b++) wr(3'd2, 8'((g * 8 + b) * 7 + 3));
            wr(3'd0, 8'(8'h40 + g * 8));
            unlock(); wr(3'd3, 8'h13);
            wait_idle(n);
            chk(n == OPC, "R7 program stall", n, OPC);
        end
        for (int i = 0; i < 64; i++)
            chk(fmem[8'h40 + i] == 8'(i * 7 + 3), "R6 row readback",
                fmem[8'h40 + i], 8'(i * 7 + 3));
        chk(stray_writes == 0, "R5 no stray writes", stray_writes, 0);
    endtask

    task automatic finish_run();
        if (!reported) begin
            reported = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_load_ptr();
        t_key_rules();
        t_range_and_program();
        t_row_update();
        finish_run();
    end
endmodule